// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Controller

This block collects 64 interrupt sources and presents them to a processor as two request lines. A fast class serves the most urgent work and a normal class serves the rest. Each source has a pending flag that a rising input edge sets. A per-source enable bit gates the flag, and a 3-bit priority value decides which class the source belongs to and how it ranks inside that class. Software works through a single-cycle 32-bit register bus. It reads pending status split by class, clears pending flags by writing ones, programs enables and priorities, and reads an entry register per class that names the current winner.

The sources are split into two banks of 32. A source with index `n` sits at bit `n mod 32` of the bank registers, and indices 32 to 63 belong to bank 1. Priorities are packed eight to a word, one nibble per source, and only the low three bits of each nibble are stored. Two general read/write words are provided for software: a control word and an entry-base word. The controller keeps their values and does not otherwise use them.

Top module: `irqc_top`

## Requirements
- R1: A rising edge on `src_i[n]` sets the pending flag of source n at the next clock edge. The flag stays set after the input falls and remains set until software clears it.
- R2: The status words are 0x00 and 0x04 for the fast class and 0x08 and 0x0C for the normal class, with bank 0 at the lower address of each pair. Each reads the pending flags of the sources whose priority falls in that class. Writing a 1 to a bit of either status word of a bank clears that pending flag, and a 0 bit leaves the flag unchanged.
- R3: When a rising edge and a software clear of the same flag occur in the same cycle, the flag ends up set.
- R4: The enable words are 0x18 (bank 0) and 0x1C (bank 1), and both reset to 0. A disabled source keeps its pending flag, but it drives neither request output nor either entry word.
- R5: The priority words are 0x30 to 0x4C. Source n uses bits `[4*(n mod 8)+2 : 4*(n mod 8)]` of word `0x30 + 4*(n/8)`. Bit 3 of every nibble reads 0, and every priority resets to 7.
- R6: Priority values 0 and 1 place a source in the fast class and values 2 to 7 place it in the normal class. `fast_req_o` or `norm_req_o` is high exactly when at least one enabled, pending source of that class exists.
- R7: The entry words are 0x10 for the fast class and 0x14 for the normal class, and both are read-only. Each returns the winner's index plus 1, or 0 when the class has no candidate. The winner is the enabled pending source with the smallest priority value, and a tie goes to the lower index.
- R8: The control word 0x20 and the entry-base word 0x24 store and return any 32-bit value, and both reset to 0.
- R9: Reads of unmapped offsets (for example 0x28, 0x2C and 0x50) return 0, and writes to them change no register.
- R10: After reset no flag is pending and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source inputs, captured on their rising edges |
| bus_we_i | input | 1 | Write strobe, qualified by the address |
| bus_addr_i | input | 8 | Byte offset of the accessed word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address, available in the same cycle |
| fast_req_o | output | 1 | Fast-class request |
| norm_req_o | output | 1 | Normal-class request |

## Verification
Arbitration is tried with several candidate patterns. In one, two normal sources have equal priority, which shows the lower index winning the tie. The same pair is then given different priorities, so that the higher index wins and priority is shown to outrank index. A matching pair of tests in the fast class is run with priorities 1 and 0. Moving a single source from priority 7 to 1 shows that it changes class, appearing in the fast status and request and leaving the normal ones. A rising edge that lands together with a clear of the same flag shows that hardware takes precedence. Writes of all zeros and writes to unmapped offsets show that these leave the stored state unchanged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned PRIO_W  = 3;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned FAST_LIM = 2;   // priorities below this are fast

    // word indices (byte offset >> 2)
    localparam logic [5:0] W_FSTAT0 = 6'd0;
    localparam logic [5:0] W_FSTAT1 = 6'd1;
    localparam logic [5:0] W_NSTAT0 = 6'd2;
    localparam logic [5:0] W_NSTAT1 = 6'd3;
    localparam logic [5:0] W_FENTRY = 6'd4;
    localparam logic [5:0] W_NENTRY = 6'd5;
    localparam logic [5:0] W_EN0    = 6'd6;
    localparam logic [5:0] W_EN1    = 6'd7;
    localparam logic [5:0] W_CTRL   = 6'd8;
    localparam logic [5:0] W_BASE   = 6'd9;
    localparam logic [5:0] W_PRIO0  = 6'd12;

    function automatic logic is_fast(input logic [PRIO_W-1:0] p);
        return p < PRIO_W'(FAST_LIM);
    endfunction
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] src;
        logic [N-1:0] pend;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.src  = src_i;
        // a fresh edge overrides a simultaneous software clear
        st_d.pend = (st_q.pend & ~clr_i) | (src_i & ~st_q.src);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R1: a flag that was not cleared stays set
    p_hold_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(st_q.pend) & ~$past(clr_i)) & ~st_q.pend) == '0));

    // R3: every observed rising edge leaves its flag set, clear or not
    p_edge_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(src_i) & ~$past(st_q.src)) & ~st_q.pend) == '0));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned N      = 64,
    parameter int unsigned PW     = 3,
    parameter int unsigned DW     = 32,
    localparam int unsigned IDXW  = $clog2(N)
) (
    input  logic [N-1:0]         cand_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 req_o,
    output logic [IDXW-1:0]      idx_o,
    output logic [DW-1:0]        entry_o
);
    logic            found;
    logic [PW-1:0]   best_p;
    logic [IDXW-1:0] best_i;

    always_comb begin
        found  = 1'b0;
        best_p = '1;
        best_i = '0;
        for (int i = 0; i < int'(N); i++) begin
            // strict compare keeps the lower index on a tie
            if (cand_i[i] && (!found || prio_i[i] < best_p)) begin
                found  = 1'b1;
                best_p = prio_i[i];
                best_i = IDXW'(i);
            end
        end
    end

    assign req_o   = found;
    assign idx_o   = best_i;
    assign entry_o = found ? (DW'(best_i) + DW'(1)) : '0;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC  = 64,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              fast_req_o,
    output logic              norm_req_o
);
    localparam int unsigned IDXW     = $clog2(N_SRC);
    localparam int unsigned N_BANK   = N_SRC / DATA_W;
    localparam int unsigned PER_WORD = DATA_W / NIB_W;
    localparam int unsigned N_PWORD  = N_SRC / PER_WORD;

    typedef struct packed {
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
        logic [DATA_W-1:0]            ctrl;
        logic [DATA_W-1:0]            base;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic [5:0]       word;
    logic [N_SRC-1:0] clr, pend, fast_mask;
    logic [1:0]       cls_req;
    logic [IDXW-1:0]  win_idx   [2];
    logic [DATA_W-1:0] win_entry [2];

    assign word = bus_addr_i[7:2];

    always_comb begin
        for (int i = 0; i < int'(N_SRC); i++) fast_mask[i] = is_fast(rg_q.prio[i]);
    end

    // write-one-to-clear from either status word of a bank
    always_comb begin
        clr = '0;
        for (int b = 0; b < int'(N_BANK); b++) begin
            if (bus_we_i && (word == W_FSTAT0 + 6'(b) || word == W_NSTAT0 + 6'(b)))
                clr[b*DATA_W +: DATA_W] = bus_wdata_i;
        end
    end

    irqc_capture #(.N(N_SRC)) u_cap (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr), .pend_o(pend)
    );

    // class 0 = fast, class 1 = normal
    for (genvar g = 0; g < 2; g++) begin : g_cls
        logic [N_SRC-1:0] cand;
        assign cand = pend & rg_q.en & ((g == 0) ? fast_mask : ~fast_mask);
        irqc_arbiter #(.N(N_SRC), .PW(PRIO_W), .DW(DATA_W)) u_arb (
            .cand_i(cand), .prio_i(rg_q.prio), .req_o(cls_req[g]),
            .idx_o(win_idx[g]), .entry_o(win_entry[g])
        );
    end

    assign fast_req_o = cls_req[0];
    assign norm_req_o = cls_req[1];

    // register writes
    always_comb begin
        rg_d = rg_q;
        if (bus_we_i) begin
            for (int b = 0; b < int'(N_BANK); b++)
                if (word == W_EN0 + 6'(b)) rg_d.en[b*DATA_W +: DATA_W] = bus_wdata_i;
            if (word == W_CTRL) rg_d.ctrl = bus_wdata_i;
            if (word == W_BASE) rg_d.base = bus_wdata_i;
            for (int k = 0; k < int'(N_PWORD); k++)
                if (word == W_PRIO0 + 6'(k))
                    for (int j = 0; j < int'(PER_WORD); j++)
                        rg_d.prio[k*PER_WORD + j] = bus_wdata_i[j*NIB_W +: PRIO_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q.en   <= '0;
            rg_q.prio <= '1;
            rg_q.ctrl <= '0;
            rg_q.base <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        for (int b = 0; b < int'(N_BANK); b++) begin
            if (word == W_FSTAT0 + 6'(b))
                bus_rdata_o = pend[b*DATA_W +: DATA_W] & fast_mask[b*DATA_W +: DATA_W];
            if (word == W_NSTAT0 + 6'(b))
                bus_rdata_o = pend[b*DATA_W +: DATA_W] & ~fast_mask[b*DATA_W +: DATA_W];
            if (word == W_EN0 + 6'(b))
                bus_rdata_o = rg_q.en[b*DATA_W +: DATA_W];
        end
        if (word == W_FENTRY) bus_rdata_o = win_entry[0];
        if (word == W_NENTRY) bus_rdata_o = win_entry[1];
        if (word == W_CTRL)   bus_rdata_o = rg_q.ctrl;
        if (word == W_BASE)   bus_rdata_o = rg_q.base;
        for (int k = 0; k < int'(N_PWORD); k++)
            if (word == W_PRIO0 + 6'(k))
                for (int j = 0; j < int'(PER_WORD); j++)
                    bus_rdata_o[j*NIB_W +: PRIO_W] = rg_q.prio[k*PER_WORD + j];
    end

    // R7: the fast winner is an enabled pending fast source
    p_fast_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req_o |-> (pend[win_idx[0]] && rg_q.en[win_idx[0]]
                        && rg_q.prio[win_idx[0]] < PRIO_W'(FAST_LIM)));

    // R6: the normal winner belongs to the normal class
    p_norm_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        norm_req_o |-> (pend[win_idx[1]] && rg_q.en[win_idx[1]]
                        && rg_q.prio[win_idx[1]] >= PRIO_W'(FAST_LIM)));

    // R4: no request without an enabled pending flag
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & rg_q.en) == '0) |-> (!fast_req_o && !norm_req_o));

    // R10: nothing pending in the first cycle after reset
    p_reset_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pend == '0));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        fast_req, norm_req;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_vld = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        bit          is_req;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we_i(bus_we),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .fast_req_o(fast_req), .norm_req_o(norm_req)
    );

    // monitor: samples before the next rising edge
    always begin
        item_t       it;
        logic [31:0] act;
        @(negedge clk);
        #3;
        if (mon_vld && sbq.size() > 0) begin
            it  = sbq.pop_front();
            act = it.is_req ? {30'b0, fast_req, norm_req} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; mon_vld = 1'b1;
        sbq.push_back('{e, 1'b0, tag});
    endtask

    // expected value: bit1 = fast request, bit0 = normal request
    task automatic rq(input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_we = 1'b0; mon_vld = 1'b1;
        sbq.push_back('{e, 1'b1, tag});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; mon_vld = 1'b0;
    endtask

    task automatic wr_src(input logic [7:0] a, input logic [31:0] d, input logic [63:0] s);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; src = s; mon_vld = 1'b0;
    endtask

    task automatic drive(input logic [63:0] s);
        @(negedge clk);
        bus_we = 1'b0; src = s; mon_vld = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; src = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(8'h00, 32'h0, "R10 fast status bank0");
        rd(8'h04, 32'h0, "R10 fast status bank1");
        rd(8'h08, 32'h0, "R10 normal status bank0");
        rd(8'h0C, 32'h0, "R10 normal status bank1");
        rq(32'h0,        "R10 requests low");
        rd(8'h18, 32'h0, "R4 enable bank0 reset");
        rd(8'h1C, 32'h0, "R4 enable bank1 reset");
        rd(8'h30, 32'h77777777, "R5 priority reset");
        rd(8'h4C, 32'h77777777, "R5 last priority word reset");
        rd(8'h10, 32'h0, "R7 fast entry idle");
        rd(8'h14, 32'h0, "R7 normal entry idle");
        rd(8'h20, 32'h0, "R8 control reset");
        rd(8'h24, 32'h0, "R8 base reset");

        // edge capture and hold
        drive(64'h8);
        rd(8'h08, 32'h8, "R1 edge sets flag");
        rq(32'h0,        "R4 disabled source silent");
        rd(8'h14, 32'h0, "R4 disabled source no entry");
        drive(64'h0);
        rd(8'h08, 32'h8, "R1 flag held after fall");

        // enable
        wr(8'h18, 32'h8);
        rq(32'h1,        "R6 normal request");
        rd(8'h14, 32'd4, "R7 normal entry source 3");

        // move source 3 to fast class; bit3 of nibble 7 dropped
        wr(8'h30, 32'hF7771777);
        rd(8'h30, 32'h77771777, "R5 nibble bit3 reads 0");
        rd(8'h00, 32'h8, "R2 fast status shows source 3");
        rd(8'h08, 32'h0, "R2 normal status empty");
        rq(32'h2,        "R6 fast request only");
        rd(8'h10, 32'd4, "R7 fast entry source 3");
        rd(8'h14, 32'h0, "R7 normal entry empty");

        // upper bank, tie on priority 2
        wr(8'h40, 32'h77772777);
        wr(8'h44, 32'h77777772);
        wr(8'h1C, 32'h108);
        drive(64'h0000_0108_0000_0000);
        rd(8'h0C, 32'h108, "R2 upper bank normal status");
        rd(8'h14, 32'd36, "R7 tie goes to lower index");
        rq(32'h3,         "R6 both requests");
        wr(8'h40, 32'h77774777);
        rd(8'h14, 32'd41, "R7 smaller priority beats lower index");

        // fast class tie and priority order
        wr(8'h30, 32'h77771717);
        wr(8'h18, 32'hA);
        drive(64'h0000_0108_0000_0002);
        rd(8'h10, 32'd2, "R7 fast tie lower index");
        wr(8'h30, 32'h77770717);
        rd(8'h10, 32'd4, "R7 fast priority 0 wins");
        rd(8'h00, 32'hA, "R2 fast status two flags");

        // write-one-to-clear
        wr(8'h00, 32'h2);
        rd(8'h00, 32'h8, "R2 clear source 1 only");
        wr(8'h0C, 32'h100);
        rd(8'h0C, 32'h8, "R2 clear source 40");
        rd(8'h14, 32'd36, "R7 entry after clear");
        wr(8'h08, 32'h0);
        rd(8'h00, 32'h8, "R2 zero write keeps fast flags");
        rd(8'h0C, 32'h8, "R2 zero write keeps bank1");

        // simultaneous edge and clear
        wr_src(8'h08, 32'h20, 64'h0000_0108_0000_0022);
        rd(8'h08, 32'h20, "R3 edge wins over clear");
        wr(8'h08, 32'h20);
        rd(8'h08, 32'h0, "R2 plain clear");

        // plain storage words
        wr(8'h20, 32'hDEADBEEF);
        wr(8'h24, 32'h12345678);
        rd(8'h20, 32'hDEADBEEF, "R8 control readback");
        rd(8'h24, 32'h12345678, "R8 base readback");

        // unmapped
        wr(8'h28, 32'hFFFFFFFF);
        wr(8'h50, 32'hFFFFFFFF);
        rd(8'h28, 32'h0, "R9 unmapped 0x28");
        rd(8'h2C, 32'h0, "R9 unmapped 0x2C");
        rd(8'h50, 32'h0, "R9 unmapped 0x50");
        rd(8'h20, 32'hDEADBEEF, "R9 control untouched");
        rd(8'h18, 32'hA, "R9 enable untouched");

        // disable all: flags kept, requests drop
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h0);
        rq(32'h0,        "R4 all disabled");
        rd(8'h00, 32'h8, "R4 flag kept while disabled");
        rd(8'h10, 32'h0, "R4 fast entry empty when disabled");

        drive(src);
        drive(src);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): got hang expected finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule